// File: doc/BRIEF.md
# Distance-Weighted Track-Cell Accumulator Array

This block is a small grid of track-finding cells, one per point of a two-dimensional track-parameter grid. Each cell owns a fixed receptor position in hit-coordinate space. Every hit on the input is offered to all cells at once. Each cell turns its distance from the hit into a graded weight and adds that weight to a running total for the current event. The result is a smooth activation map instead of a yes/no pattern match.

An event opens with a start pulse, which clears the cells' sums. It closes with an end pulse. After the end pulse, every cell compares its total with its eight surrounding cells. A cell that is a local maximum and reaches a programmable threshold becomes a track candidate. Candidates leave the block one record per cycle. Each record carries the grid row and column, the cell's own sum and the sums of its four edge neighbours, so that a later stage can interpolate a centroid.

Two sets of sums alternate between events. The next event can therefore collect hits while the previous one is still being read out. The readout schedule is fixed: it does not depend on the number of hits or on the number of candidates.

Top module: `retina_accum_array`

## Requirements
- R1: A hit at coordinates (x,y) adds a weight to the cell whose receptor sits at (col*16+8, row*16+8). Let qx = |x-rx|>>2 and qy = |y-ry|>>2, and d2 = qx*qx+qy*qy. The weight is 8 for d2=0, 4 for d2=1, 2 for d2=2, and 0 for d2 greater than 2.
- R2: A start pulse clears the sums of the event being filled. Every hit of that event then adds its weight to every cell. Sums from earlier events never carry over.
- R3: A cell is flagged as a candidate only if its sum is at least `thresh` and it beats all of its up to 8 in-grid neighbours. Cells outside the grid are ignored.
- R4: Cell index is row*COLS+col. On equal sums, the cell with the lower index wins. A cell must be strictly greater than each lower-index neighbour, and greater than or equal to each higher-index neighbour.
- R5: A candidate record gives `cand_row`, `cand_col`, the cell's sum, and the sums of the cells above (row-1), below (row+1), left (col-1) and right (col+1). A neighbour that falls outside the grid reads as 0.
- R6: Suppose the end pulse is sampled at clock edge E. Then the result slot of cell k occupies the cycle after edge E+2+k. `cand_valid` is high in that slot only if cell k is a candidate, and it is low in every other cycle.
- R7: A hit sampled in the same cycle as the end pulse belongs to the closing event. A start pulse and hits that arrive during a readout fill the other set of sums and do not alter the records being read out.
- R8: While reset is held low, `cand_valid` is low after each clock edge.
- R9: A cell whose sum is below `thresh` never produces a record, even if it is a local maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | Opens an event and clears the sums it will fill |
| evt_end | input | 1 | Closes the event and starts its readout |
| hit_valid | input | 1 | Qualifies hit_x/hit_y for this cycle |
| hit_x | input | CW (8) | Hit coordinate along the column axis |
| hit_y | input | CW (8) | Hit coordinate along the row axis |
| thresh | input | SW (12) | Minimum sum for a candidate |
| cand_valid | output | 1 | A candidate record is present |
| cand_row | output | log2(ROWS) | Grid row of the candidate |
| cand_col | output | log2(COLS) | Grid column of the candidate |
| cand_sum | output | SW | Candidate cell's own sum |
| cand_n | output | SW | Sum of the cell at row-1 (0 off-grid) |
| cand_s | output | SW | Sum of the cell at row+1 (0 off-grid) |
| cand_w | output | SW | Sum of the cell at col-1 (0 off-grid) |
| cand_e | output | SW | Sum of the cell at col+1 (0 off-grid) |

## Verification
The input patterns are chosen to separate the ways the block can go wrong:
- A lone hit on a receptor, and hits offset by one quantum along one axis and along the diagonal, separate the weight steps from one another.
- Two hits piled on neighbouring cells separate accumulation from a single-hit result. Running the same hit against a threshold just above its sum isolates the threshold rule.
- Two distant clusters show that several candidates come out in index order. Two adjacent cells with equal sums show which of them the tie rule selects.
- A hit coinciding with the end pulse, followed by a new event whose start and hits overlap the readout, separates correct bank alternation from corruption of the records being read out. The overlapping event is then read out on its own as well.

// File: rtl/retina_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the track-cell accumulator array.
// Assumes distances are already quantized and squared by the caller.
package retina_pkg;

    // Weight falloff: halves per unit of squared quantized distance, zero past the cutoff.
    function automatic int unsigned falloff(input int unsigned d2,
                                            input int unsigned wmax,
                                            input int unsigned cut2);
        if (d2 > cut2) return 0;
        return wmax >> d2;
    endfunction

endpackage

// File: rtl/retina_cell.sv
`timescale 1ns/1ps
// One grid cell: weighs each hit by its distance to this cell's receptor
// and accumulates into one of two sums, picked by fill_sel.
// Assumes evt_start and the fill bank select are supplied by the array control.
module retina_cell #(
    parameter int CW   = 8,
    parameter int SW   = 12,
    parameter int RX   = 8,
    parameter int RY   = 8,
    parameter int QSH  = 2,
    parameter int WMAX = 8,
    parameter int CUT2 = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_start,
    input  logic          hit_valid,
    input  logic [CW-1:0] hit_x,
    input  logic [CW-1:0] hit_y,
    input  logic          fill_sel,
    input  logic          rd_sel,
    output logic [SW-1:0] sum_rd
);
    logic [CW-1:0] dx, dy, qx, qy;
    int unsigned   d2;
    logic [SW-1:0] wgt;
    logic [SW-1:0] bank [2];

    // Distance to receptor, quantized, squared and mapped to a weight.
    always_comb begin
        dx  = (hit_x >= CW'(RX)) ? hit_x - CW'(RX) : CW'(RX) - hit_x;
        dy  = (hit_y >= CW'(RY)) ? hit_y - CW'(RY) : CW'(RY) - hit_y;
        qx  = dx >> QSH;
        qy  = dy >> QSH;
        d2  = 32'(qx) * 32'(qx) + 32'(qy) * 32'(qy);
        wgt = SW'(retina_pkg::falloff(d2, WMAX, CUT2));
    end

    // Clear-on-start and accumulate into the bank currently being filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= '0;
            bank[1] <= '0;
        end else if (evt_start) begin
            bank[fill_sel] <= hit_valid ? wgt : '0;
        end else if (hit_valid) begin
            bank[fill_sel] <= bank[fill_sel] + wgt;
        end
    end

    assign sum_rd = bank[rd_sel];
endmodule

// File: rtl/retina_peak.sv
`timescale 1ns/1ps
// Local-maximum finder over the whole grid, plus edge-neighbour gathering.
// Assumes sums are stable while the result is used (read bank is frozen).
module retina_peak #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int SW   = 12,
    localparam int N   = ROWS * COLS
) (
    input  logic [SW-1:0] sums   [N],
    input  logic [SW-1:0] thresh,
    output logic [N-1:0]  is_peak,
    output logic [SW-1:0] nb_n   [N],
    output logic [SW-1:0] nb_s   [N],
    output logic [SW-1:0] nb_w   [N],
    output logic [SW-1:0] nb_e   [N]
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K = r * COLS + c;
            logic [8:0] beat;
            // Compare against each of the 8 surrounding positions; tie goes to lower index.
            for (genvar d = 0; d < 9; d++) begin : g_nb
                localparam int NR = r + d / 3 - 1;
                localparam int NC = c + d % 3 - 1;
                localparam int J  = NR * COLS + NC;
                if (d == 4 || NR < 0 || NR >= ROWS || NC < 0 || NC >= COLS) begin : g_skip
                    assign beat[d] = 1'b1;
                end else if (J < K) begin : g_lo
                    assign beat[d] = sums[K] > sums[J];
                end else begin : g_hi
                    assign beat[d] = sums[K] >= sums[J];
                end
            end
            assign is_peak[K] = (&beat) && (sums[K] >= thresh);

            if (r > 0)        begin : g_n assign nb_n[K] = sums[K-COLS]; end
            else              begin : g_n0 assign nb_n[K] = '0; end
            if (r < ROWS - 1) begin : g_s assign nb_s[K] = sums[K+COLS]; end
            else              begin : g_s0 assign nb_s[K] = '0; end
            if (c > 0)        begin : g_w assign nb_w[K] = sums[K-1]; end
            else              begin : g_w0 assign nb_w[K] = '0; end
            if (c < COLS - 1) begin : g_e assign nb_e[K] = sums[K+1]; end
            else              begin : g_e0 assign nb_e[K] = '0; end
        end
    end
endmodule

// File: rtl/retina_accum_array.sv
`timescale 1ns/1ps
// Grid of distance-weighted accumulating cells with local-maximum readout.
// Two sum banks alternate per event; readout scans every cell in index order
// at a fixed cycle after end of event. Assumes events last at least N+3 cycles
// and that thresh is held steady during a readout.
module retina_accum_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int CW    = 8,
    parameter int SW    = 12,
    parameter int PITCH = 16,
    parameter int OFS   = 8,
    parameter int QSH   = 2,
    parameter int WMAX  = 8,
    parameter int CUT2  = 2,
    localparam int N    = ROWS * COLS,
    localparam int RW   = $clog2(ROWS),
    localparam int CLW  = $clog2(COLS),
    localparam int KW   = $clog2(N),
    localparam int STW  = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_start,
    input  logic           evt_end,
    input  logic           hit_valid,
    input  logic [CW-1:0]  hit_x,
    input  logic [CW-1:0]  hit_y,
    input  logic [SW-1:0]  thresh,
    output logic           cand_valid,
    output logic [RW-1:0]  cand_row,
    output logic [CLW-1:0] cand_col,
    output logic [SW-1:0]  cand_sum,
    output logic [SW-1:0]  cand_n,
    output logic [SW-1:0]  cand_s,
    output logic [SW-1:0]  cand_w,
    output logic [SW-1:0]  cand_e
);
    logic           fill_sel, rd_sel, active;
    logic [STW-1:0] step;
    logic [KW-1:0]  idx;
    logic [N-1:0]   is_peak, flag_q;
    logic [SW-1:0]  sums [N];
    logic [SW-1:0]  nb_n [N];
    logic [SW-1:0]  nb_s [N];
    logic [SW-1:0]  nb_w [N];
    logic [SW-1:0]  nb_e [N];
    logic [RW-1:0]  row_of [N];
    logic [CLW-1:0] col_of [N];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K = r * COLS + c;
            retina_cell #(
                .CW(CW), .SW(SW), .RX(c * PITCH + OFS), .RY(r * PITCH + OFS),
                .QSH(QSH), .WMAX(WMAX), .CUT2(CUT2)
            ) u_cell (
                .clk(clk), .rst_n(rst_n), .evt_start(evt_start),
                .hit_valid(hit_valid), .hit_x(hit_x), .hit_y(hit_y),
                .fill_sel(fill_sel), .rd_sel(rd_sel), .sum_rd(sums[K])
            );
            assign row_of[K] = RW'(r);
            assign col_of[K] = CLW'(c);
        end
    end

    retina_peak #(.ROWS(ROWS), .COLS(COLS), .SW(SW)) u_peak (
        .sums(sums), .thresh(thresh), .is_peak(is_peak),
        .nb_n(nb_n), .nb_s(nb_s), .nb_w(nb_w), .nb_e(nb_e)
    );

    assign idx = KW'(step - STW'(1));

    // Bank swap on end of event and readout step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
            rd_sel   <= 1'b0;
            active   <= 1'b0;
            step     <= '0;
        end else if (evt_end) begin
            fill_sel <= ~fill_sel;
            rd_sel   <= fill_sel;
            active   <= 1'b1;
            step     <= '0;
        end else if (active) begin
            if (step == STW'(N)) active <= 1'b0;
            else                 step   <= step + STW'(1);
        end
    end

    // Capture the peak flags of the frozen bank once per readout.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= '0;
        else if (active && step == '0)   flag_q <= is_peak;
    end

    // Emit one cell's slot per cycle; valid only where a peak was flagged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_row   <= '0;
            cand_col   <= '0;
            cand_sum   <= '0;
            cand_n     <= '0;
            cand_s     <= '0;
            cand_w     <= '0;
            cand_e     <= '0;
        end else if (active && step != '0) begin
            cand_valid <= flag_q[idx];
            cand_row   <= row_of[idx];
            cand_col   <= col_of[idx];
            cand_sum   <= sums[idx];
            cand_n     <= nb_n[idx];
            cand_s     <= nb_s[idx];
            cand_w     <= nb_w[idx];
            cand_e     <= nb_e[idx];
        end else begin
            cand_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/retina_accum_chk.sv
`timescale 1ns/1ps
// Port-level checker for the accumulator array, attached with bind.
// Assumes thresh is held steady across each readout.
module retina_accum_chk #(
    parameter int RW  = 2,
    parameter int CLW = 2,
    parameter int SW  = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic [SW-1:0]  thresh,
    input logic           cand_valid,
    input logic [RW-1:0]  cand_row,
    input logic [CLW-1:0] cand_col,
    input logic [SW-1:0]  cand_sum,
    input logic [SW-1:0]  cand_n,
    input logic [SW-1:0]  cand_s,
    input logic [SW-1:0]  cand_w,
    input logic [SW-1:0]  cand_e
);
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> !cand_valid);

    assert_meets_thresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> cand_sum >= thresh);

    assert_dominates_nb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_sum >= cand_s) && (cand_sum >= cand_e));

    assert_tie_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_row == '0 || cand_sum > cand_n) &&
                       (cand_col == '0 || cand_sum > cand_w));

    assert_offgrid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_row != '0 || cand_n == '0) &&
                       (cand_col != '0 || cand_w == '0));

    assert_scan_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && $past(cand_valid)) |->
            {cand_row, cand_col} > $past({cand_row, cand_col}));
endmodule

bind retina_accum_array retina_accum_chk #(.RW(RW), .CLW(CLW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .cand_valid(cand_valid),
    .cand_row(cand_row), .cand_col(cand_col), .cand_sum(cand_sum),
    .cand_n(cand_n), .cand_s(cand_s), .cand_w(cand_w), .cand_e(cand_e)
);

// File: tb/retina_accum_array_tb.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of events, then directed reset,
// end-on-hit and overlapping-event tests.
module retina_accum_array_tb;
    localparam int ROWS = 4, COLS = 4, N = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        evt_start = 0, evt_end = 0, hit_valid = 0;
    logic [7:0]  hit_x = 0, hit_y = 0;
    logic [11:0] thresh = 0;
    logic        cand_valid;
    logic [1:0]  cand_row, cand_col;
    logic [11:0] cand_sum, cand_n, cand_s, cand_w, cand_e;

    retina_accum_array u_dut (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_end(evt_end),
        .hit_valid(hit_valid), .hit_x(hit_x), .hit_y(hit_y), .thresh(thresh),
        .cand_valid(cand_valid), .cand_row(cand_row), .cand_col(cand_col),
        .cand_sum(cand_sum), .cand_n(cand_n), .cand_s(cand_s),
        .cand_w(cand_w), .cand_e(cand_e)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    localparam int NV = 6;
    localparam int V_N   [NV]    = '{1, 2, 1, 2, 2, 2};
    localparam int V_THR [NV]    = '{4, 10, 9, 4, 4, 1};
    localparam int V_HX  [NV][2] = '{'{8,0}, '{40,44}, '{8,0}, '{8,56}, '{8,24}, '{8,12}};
    localparam int V_HY  [NV][2] = '{'{8,0}, '{24,24}, '{8,0}, '{8,56}, '{8,8},  '{8,12}};
    localparam string V_REQ [NV] = '{"R1", "R2", "R9", "R3", "R4", "R1"};

    int cur_n, cur_hx[4], cur_hy[4];
    int nxt_n, nxt_hx[4], nxt_hy[4];
    bit pre_started = 0;
    int exp_sum[N];
    bit exp_flag[N];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Weight rule taken from R1.
    function automatic int weight(int x, int y, int r, int c);
        int dx = x - (c * 16 + 8);
        int dy = y - (r * 16 + 8);
        int d2;
        if (dx < 0) dx = -dx;
        if (dy < 0) dy = -dy;
        d2 = (dx / 4) * (dx / 4) + (dy / 4) * (dy / 4);
        return (d2 == 0) ? 8 : (d2 == 1) ? 4 : (d2 == 2) ? 2 : 0;
    endfunction

    function automatic int nb(int r, int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return -1;
        return exp_sum[r * COLS + c];
    endfunction

    // Expected sums and flags from R1..R4 and R9.
    task automatic model(int thr);
        for (int k = 0; k < N; k++) begin
            exp_sum[k] = 0;
            for (int h = 0; h < cur_n; h++)
                exp_sum[k] += weight(cur_hx[h], cur_hy[h], k / COLS, k % COLS);
        end
        for (int k = 0; k < N; k++) begin
            bit ok = (exp_sum[k] >= thr);
            for (int d = 0; d < 9; d++) begin
                int nr = k / COLS + d / 3 - 1;
                int nc = k % COLS + d % 3 - 1;
                int v = nb(nr, nc);
                if (d != 4 && v >= 0) begin
                    if (nr * COLS + nc < k) ok &= (exp_sum[k] > v);
                    else                    ok &= (exp_sum[k] >= v);
                end
            end
            exp_flag[k] = ok;
        end
    endtask

    task automatic fill(bit end_on_hit);
        if (!pre_started) begin
            evt_start = 1; step(); evt_start = 0;
            for (int i = 0; i < cur_n; i++) begin
                hit_valid = 1; hit_x = 8'(cur_hx[i]); hit_y = 8'(cur_hy[i]);
                if (end_on_hit && i == cur_n - 1) evt_end = 1;
                step();
            end
            hit_valid = 0;
        end
        if (!(end_on_hit && cur_n > 0 && !pre_started)) begin
            evt_end = 1; step();
        end
        pre_started = 0;
    endtask

    // Called right after the edge that sampled evt_end (edge E + 2 ns).
    task automatic drain(int thr, bit skew, string req);
        model(thr);
        evt_end = 0;
        if (skew) evt_start = 1;
        step();
        evt_start = 0;
        chk(cand_valid == 0, "R6 before window", int'(cand_valid), 0);
        for (int k = 0; k < N; k++) begin
            step();
            chk(cand_valid == exp_flag[k], $sformatf("%s/R6 valid cell %0d", req, k),
                int'(cand_valid), int'(exp_flag[k]));
            if (exp_flag[k]) begin
                int r = k / COLS, c = k % COLS;
                int en = (r > 0) ? exp_sum[k - COLS] : 0;
                int es = (r < ROWS - 1) ? exp_sum[k + COLS] : 0;
                int ew = (c > 0) ? exp_sum[k - 1] : 0;
                int ee = (c < COLS - 1) ? exp_sum[k + 1] : 0;
                chk(int'(cand_row) == r, "R5 row", int'(cand_row), r);
                chk(int'(cand_col) == c, "R5 col", int'(cand_col), c);
                chk(int'(cand_sum) == exp_sum[k], $sformatf("%s/R1 sum", req),
                    int'(cand_sum), exp_sum[k]);
                chk(int'(cand_n) == en, "R5 north", int'(cand_n), en);
                chk(int'(cand_s) == es, "R5 south", int'(cand_s), es);
                chk(int'(cand_w) == ew, "R5 west", int'(cand_w), ew);
                chk(int'(cand_e) == ee, "R5 east", int'(cand_e), ee);
            end
            if (skew && k < nxt_n) begin
                hit_valid = 1; hit_x = 8'(nxt_hx[k]); hit_y = 8'(nxt_hy[k]);
            end else begin
                hit_valid = 0;
            end
        end
        hit_valid = 0;
        step();
        chk(cand_valid == 0, "R6 after window", int'(cand_valid), 0);
        if (skew) begin
            cur_n = nxt_n;
            for (int i = 0; i < nxt_n; i++) begin
                cur_hx[i] = nxt_hx[i]; cur_hy[i] = nxt_hy[i];
            end
            pre_started = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: outputs quiet during reset.
        repeat (3) step();
        chk(cand_valid == 0, "R8 reset valid", int'(cand_valid), 0);
        rst_n = 1;
        step();
        chk(cand_valid == 0, "R8 after release", int'(cand_valid), 0);

        // Vector walk: each entry is one event (R1, R2, R3, R4, R9).
        for (int v = 0; v < NV; v++) begin
            cur_n = V_N[v];
            for (int i = 0; i < cur_n; i++) begin
                cur_hx[i] = V_HX[v][i]; cur_hy[i] = V_HY[v][i];
            end
            thresh = 12'(V_THR[v]);
            fill(0);
            drain(V_THR[v], 0, V_REQ[v]);
            repeat (2) step();
        end

        // R7: hit on the end cycle counts; the overlapping event must not disturb readout.
        cur_n = 1; cur_hx[0] = 8; cur_hy[0] = 8;
        nxt_n = 3;
        nxt_hx = '{56, 52, 40, 0}; nxt_hy = '{56, 56, 40, 0};
        thresh = 4;
        fill(1);
        drain(4, 1, "R7 end-hit");
        fill(0);
        drain(4, 0, "R7 overlap event");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule